// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides, for each incoming frame, whether it is kept or dropped by looking at the frame length and the six destination address bytes. It holds a station address register, a 64-entry multicast hash table and takes its filter mode from configuration inputs: promiscuous, broadcast disable, accept-multicast and a minimum frame length. The hash index is computed on the fly by a byte-serial CRC-32 engine, both when frames are filtered and when the table is programmed.

A frame begins with a start pulse that carries the frame length. The receive path then feeds the destination bytes one per valid cycle, first wire byte first. One cycle after the sixth byte is taken, a single-cycle strobe reports accept or reject and whether the frame was a group (broadcast or multicast) frame. The table is programmed by a list-load start pulse carrying the list length in bytes, followed by the address bytes of the list, six per address.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: After reset the decision strobe, accept and group outputs are low, the station address is zero and the hash table is empty.
- R2: The decision strobe `dec_valid_o` rises in the cycle after the sixth destination byte is taken and lasts exactly one cycle; `dec_accept_o` and `dec_group_o` are low whenever the strobe is low.
- R3: With promiscuous mode set, every frame that passes the length check is accepted and its group flag is low.
- R4: A destination of all ones is broadcast: rejected when broadcast disable is set, otherwise accepted with the group flag high.
- R5: A destination whose first byte has bit 0 set (and is not all ones) is multicast: accepted with the group flag high only if accept-multicast is set and its hash table bit is set, otherwise rejected.
- R6: The hash index is bits 7:2 of a CRC-32 (reflected polynomial 0xEDB88320, preset all ones, no final inversion, each byte LSB first) over the six address bytes in wire order; table bit number equals the index.
- R7: A list-load start clears the whole table; the number of addresses applied is the list byte length divided by 6, rounded down, and further streamed bytes are ignored.
- R8: The number of addresses applied from one list is clamped to at most 64.
- R9: Any other destination is accepted only when all six bytes equal the station address, where wire byte k is `sta_addr_i[8k+7:8k]` captured on `sta_we_i`; otherwise it is rejected.
- R10: A frame whose length is below max(`cfg_min_len_i`, 5) is rejected, before any address rule including promiscuous mode.
- R11: The group flag is only high together with accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_promisc_i | input | 1 | Accept every frame of legal length |
| cfg_bcast_dis_i | input | 1 | Reject broadcast frames |
| cfg_mcast_en_i | input | 1 | Allow multicast frames to reach the hash check |
| cfg_min_len_i | input | LEN_W | Configured minimum frame length in bytes |
| sta_we_i | input | 1 | Load station address |
| sta_addr_i | input | 48 | Station address, wire byte k in bits 8k+7:8k |
| mc_start_i | input | 1 | Clear table and start a list load |
| mc_len_i | input | MCLEN_W | List length in bytes |
| mc_valid_i | input | 1 | List byte valid |
| mc_byte_i | input | 8 | List byte |
| rx_start_i | input | 1 | Start of frame |
| rx_len_i | input | LEN_W | Frame length in bytes |
| rx_valid_i | input | 1 | Destination byte valid |
| rx_byte_i | input | 8 | Destination byte |
| dec_valid_o | output | 1 | One-cycle decision strobe |
| dec_accept_o | output | 1 | Frame accepted |
| dec_group_o | output | 1 | Accepted broadcast or multicast frame |

## Verification
The bench builds the block with its defaults: a 6-bit hash index (64 table bits), a 64-address list limit and 16-bit length fields. With a 64-entry limit the clamp is reached by a list of 65 addresses, so overflow is exercised in a few hundred cycles. The bench picks its multicast test addresses by computing their hash indices itself, so that hit, miss, clear-before-load and clamp cases are guaranteed to land on distinct table bits.

// File: rtl/eth_rx_filt_pkg.sv
package eth_rx_filt_pkg;
  localparam int ADDR_BYTES = 6;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  function automatic logic [31:0] crc32_step(input logic [31:0] crc, input logic [7:0] din);
    logic [31:0] c;
    c = crc;
    for (int i = 0; i < 8; i++) begin
      c = (c[0] ^ din[i]) ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/eth_rx_filt_hash.sv
module eth_rx_filt_hash
  import eth_rx_filt_pkg::*;
#(
  parameter int HASH_W  = 6,
  parameter int MC_MAX  = 64,
  parameter int MCLEN_W = 16,
  localparam int TBL_N  = 1 << HASH_W,
  localparam int CNT_W  = $clog2(MC_MAX + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mc_start_i,
  input  logic [MCLEN_W-1:0] mc_len_i,
  input  logic               mc_valid_i,
  input  logic [7:0]         mc_byte_i,
  output logic [TBL_N-1:0]   table_o
);
  logic [TBL_N-1:0] table_q;
  logic [CNT_W-1:0] left_q;
  logic [2:0]       pos_q;
  logic [31:0]      crc_q, crc_n;
  logic [MCLEN_W-1:0] quot;
  logic [CNT_W-1:0]   cnt_init;
  logic [HASH_W-1:0]  idx;

  assign quot     = mc_len_i / MCLEN_W'(ADDR_BYTES);
  assign cnt_init = (quot > MCLEN_W'(MC_MAX)) ? CNT_W'(MC_MAX) : quot[CNT_W-1:0];
  assign crc_n    = crc32_step(crc_q, mc_byte_i);
  assign idx      = crc_n[HASH_W+1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      table_q <= '0;
      left_q  <= '0;
      pos_q   <= '0;
      crc_q   <= '1;
    end else if (mc_start_i) begin
      table_q <= '0;
      left_q  <= cnt_init;
      pos_q   <= '0;
      crc_q   <= '1;
    end else if (mc_valid_i && left_q != '0) begin
      if (pos_q == 3'(ADDR_BYTES - 1)) begin
        table_q[idx] <= 1'b1;
        left_q       <= left_q - 1'b1;
        pos_q        <= '0;
        crc_q        <= '1;
      end else begin
        pos_q <= pos_q + 1'b1;
        crc_q <= crc_n;
      end
    end
  end

  assign table_o = table_q;
endmodule

// File: rtl/eth_rx_filt_match.sv
module eth_rx_filt_match
  import eth_rx_filt_pkg::*;
#(
  parameter int HASH_W    = 6,
  parameter int LEN_W     = 16,
  parameter int MIN_FLOOR = 5,
  localparam int TBL_N    = 1 << HASH_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_promisc_i,
  input  logic             cfg_bcast_dis_i,
  input  logic             cfg_mcast_en_i,
  input  logic [LEN_W-1:0] cfg_min_len_i,
  input  logic [47:0]      sta_addr_i,
  input  logic [TBL_N-1:0] table_i,
  input  logic             rx_start_i,
  input  logic [LEN_W-1:0] rx_len_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_byte_i,
  output logic             dec_valid_o,
  output logic             dec_accept_o,
  output logic             dec_group_o
);
  localparam logic [2:0] POS_DONE = 3'(ADDR_BYTES);

  logic [2:0]  pos_q;
  logic [31:0] crc_q, crc_n;
  logic        ones_q, ones_n;
  logic        same_q, same_n;
  logic        mc_q, mc_n;
  logic        len_ok_q;
  logic [LEN_W-1:0] min_eff;
  logic        active, last;
  logic        acc_n, grp_n;
  logic [7:0]  sta_byte;
  logic        v_q, a_q, g_q;

  assign min_eff  = (cfg_min_len_i < LEN_W'(MIN_FLOOR)) ? LEN_W'(MIN_FLOOR) : cfg_min_len_i;
  assign active   = rx_valid_i && (pos_q != POS_DONE);
  assign last     = active && (pos_q == POS_DONE - 3'd1);
  assign sta_byte = sta_addr_i[8*pos_q +: 8];
  assign crc_n    = crc32_step(crc_q, rx_byte_i);
  assign ones_n   = ones_q && (rx_byte_i == 8'hFF);
  assign same_n   = same_q && (rx_byte_i == sta_byte);
  assign mc_n     = (pos_q == 3'd0) ? rx_byte_i[0] : mc_q;

  always_comb begin
    acc_n = 1'b0;
    grp_n = 1'b0;
    if (!len_ok_q) begin
      acc_n = 1'b0;
    end else if (cfg_promisc_i) begin
      acc_n = 1'b1;
    end else if (ones_n) begin
      acc_n = !cfg_bcast_dis_i;
      grp_n = !cfg_bcast_dis_i;
    end else if (mc_n) begin
      acc_n = cfg_mcast_en_i && table_i[crc_n[HASH_W+1:2]];
      grp_n = acc_n;
    end else begin
      acc_n = same_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= POS_DONE;
      crc_q    <= '1;
      ones_q   <= 1'b1;
      same_q   <= 1'b1;
      mc_q     <= 1'b0;
      len_ok_q <= 1'b0;
    end else if (rx_start_i) begin
      pos_q    <= '0;
      crc_q    <= '1;
      ones_q   <= 1'b1;
      same_q   <= 1'b1;
      mc_q     <= 1'b0;
      len_ok_q <= (rx_len_i >= min_eff);
    end else if (active) begin
      pos_q  <= pos_q + 1'b1;
      crc_q  <= crc_n;
      ones_q <= ones_n;
      same_q <= same_n;
      mc_q   <= mc_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= 1'b0;
      a_q <= 1'b0;
      g_q <= 1'b0;
    end else begin
      v_q <= last;
      a_q <= last && acc_n;
      g_q <= last && grp_n;
    end
  end

  assign dec_valid_o  = v_q;
  assign dec_accept_o = a_q;
  assign dec_group_o  = g_q;
endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter #(
  parameter int HASH_W    = 6,
  parameter int MC_MAX    = 64,
  parameter int LEN_W     = 16,
  parameter int MCLEN_W   = 16,
  parameter int MIN_FLOOR = 5,
  localparam int TBL_N    = 1 << HASH_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_promisc_i,
  input  logic               cfg_bcast_dis_i,
  input  logic               cfg_mcast_en_i,
  input  logic [LEN_W-1:0]   cfg_min_len_i,
  input  logic               sta_we_i,
  input  logic [47:0]        sta_addr_i,
  input  logic               mc_start_i,
  input  logic [MCLEN_W-1:0] mc_len_i,
  input  logic               mc_valid_i,
  input  logic [7:0]         mc_byte_i,
  input  logic               rx_start_i,
  input  logic [LEN_W-1:0]   rx_len_i,
  input  logic               rx_valid_i,
  input  logic [7:0]         rx_byte_i,
  output logic               dec_valid_o,
  output logic               dec_accept_o,
  output logic               dec_group_o
);
  logic [47:0]      sta_q;
  logic [TBL_N-1:0] mc_table;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sta_q <= '0;
    else if (sta_we_i) sta_q <= sta_addr_i;
  end

  eth_rx_filt_hash #(
    .HASH_W(HASH_W), .MC_MAX(MC_MAX), .MCLEN_W(MCLEN_W)
  ) u_hash (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mc_start_i (mc_start_i),
    .mc_len_i   (mc_len_i),
    .mc_valid_i (mc_valid_i),
    .mc_byte_i  (mc_byte_i),
    .table_o    (mc_table)
  );

  eth_rx_filt_match #(
    .HASH_W(HASH_W), .LEN_W(LEN_W), .MIN_FLOOR(MIN_FLOOR)
  ) u_match (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cfg_promisc_i   (cfg_promisc_i),
    .cfg_bcast_dis_i (cfg_bcast_dis_i),
    .cfg_mcast_en_i  (cfg_mcast_en_i),
    .cfg_min_len_i   (cfg_min_len_i),
    .sta_addr_i      (sta_q),
    .table_i         (mc_table),
    .rx_start_i      (rx_start_i),
    .rx_len_i        (rx_len_i),
    .rx_valid_i      (rx_valid_i),
    .rx_byte_i       (rx_byte_i),
    .dec_valid_o     (dec_valid_o),
    .dec_accept_o    (dec_accept_o),
    .dec_group_o     (dec_group_o)
  );
endmodule

// File: rtl/eth_rx_addr_filter_chk.sv
module eth_rx_addr_filter_chk #(
  parameter int TBL_N = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_promisc_i,
  input logic             mc_start_i,
  input logic [TBL_N-1:0] mc_table,
  input logic             dec_valid_o,
  input logic             dec_accept_o,
  input logic             dec_group_o
);
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |=> !dec_valid_o); // R2
  AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_o |-> (!dec_accept_o && !dec_group_o)); // R2
  AST_GROUP_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_group_o |-> dec_accept_o); // R11
  AST_PROMISC_NO_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && $past(cfg_promisc_i)) |-> !dec_group_o); // R3
  AST_TABLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_start_i |=> (mc_table == '0)); // R7
endmodule

bind eth_rx_addr_filter eth_rx_addr_filter_chk #(.TBL_N(TBL_N)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_promisc_i (cfg_promisc_i),
  .mc_start_i    (mc_start_i),
  .mc_table      (mc_table),
  .dec_valid_o   (dec_valid_o),
  .dec_accept_o  (dec_accept_o),
  .dec_group_o   (dec_group_o)
);

// File: tb/eth_rx_addr_filter_tb.sv
module eth_rx_addr_filter_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic promisc = 0, bdis = 0, mcen = 0;
  logic [15:0] minlen = 0;
  logic sta_we = 0;
  logic [47:0] sta = 0;
  logic mc_start = 0, mc_valid = 0;
  logic [15:0] mc_len = 0;
  logic [7:0] mc_byte = 0;
  logic rx_start = 0, rx_valid = 0;
  logic [15:0] rx_len = 0;
  logic [7:0] rx_byte = 0;
  logic dv, da, dg;
  int checks = 0, fails = 0;
  logic [47:0] mcl [0:79];
  logic [47:0] addr_a, addr_b, addr_c;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_rx_addr_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_promisc_i(promisc), .cfg_bcast_dis_i(bdis), .cfg_mcast_en_i(mcen),
    .cfg_min_len_i(minlen), .sta_we_i(sta_we), .sta_addr_i(sta),
    .mc_start_i(mc_start), .mc_len_i(mc_len), .mc_valid_i(mc_valid), .mc_byte_i(mc_byte),
    .rx_start_i(rx_start), .rx_len_i(rx_len), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .dec_valid_o(dv), .dec_accept_o(da), .dec_group_o(dg)
  );

  function automatic int hidx(input logic [47:0] a);
    logic [31:0] c;
    logic fb;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      fb = c[0] ^ a[k];
      c = {1'b0, c[31:1]};
      if (fb) c = c ^ 32'hEDB8_8320;
    end
    return int'(c[7:2]);
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual={v,a,g}=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic set_sta(input logic [47:0] a);
    @(negedge clk); sta_we = 1; sta = a;
    @(negedge clk); sta_we = 0;
  endtask

  task automatic load_list(input int n_addr, input int byte_len);
    @(negedge clk); mc_start = 1; mc_len = 16'(byte_len);
    @(negedge clk); mc_start = 0;
    for (int i = 0; i < n_addr; i++) begin
      for (int b = 0; b < 6; b++) begin
        mc_valid = 1; mc_byte = mcl[i][8*b +: 8];
        @(negedge clk);
      end
    end
    mc_valid = 0;
    @(negedge clk);
  endtask

  task automatic frame(input string req, input logic [47:0] a, input int len,
                       input logic exp_a, input logic exp_g);
    @(negedge clk); rx_start = 1; rx_len = 16'(len);
    @(negedge clk); rx_start = 0;
    for (int b = 0; b < 6; b++) begin
      rx_valid = 1; rx_byte = a[8*b +: 8];
      @(negedge clk);
      if (b == 4) check({req, " no early strobe"}, {dv, da, dg}, 3'b000);
    end
    rx_valid = 0;
    check(req, {dv, da, dg}, {1'b1, exp_a, exp_g});
    @(negedge clk);
    check({req, " strobe drop"}, {dv, da, dg}, 3'b000);
  endtask

  task automatic t_reset();
    check("R1 reset outputs", {dv, da, dg}, 3'b000);
    frame("R1 zero station", 48'h0, 64, 1'b1, 1'b0);
    mcen = 1;
    frame("R1 empty table", 48'h0000_0000_0001, 64, 1'b0, 1'b0);
    mcen = 0;
  endtask

  task automatic t_unicast();
    set_sta(48'h5544_3322_1100 | 48'h02);
    frame("R9 exact match", 48'h5544_3322_1102, 64, 1'b1, 1'b0);
    frame("R9 last byte differs", 48'h5644_3322_1102, 64, 1'b0, 1'b0);
    frame("R9 first byte differs", 48'h5544_3322_1104, 64, 1'b0, 1'b0);
  endtask

  task automatic t_bcast();
    frame("R4 broadcast accepted", 48'hFFFF_FFFF_FFFF, 64, 1'b1, 1'b1);
    bdis = 1;
    frame("R4 broadcast disabled", 48'hFFFF_FFFF_FFFF, 64, 1'b0, 1'b0);
    bdis = 0;
  endtask

  task automatic t_mcast();
    mcl[0] = addr_a;
    load_list(1, 6);
    mcen = 1;
    frame("R5 R6 hash hit", addr_a, 64, 1'b1, 1'b1);
    frame("R5 R6 hash miss", addr_b, 64, 1'b0, 1'b0);
    mcen = 0;
    frame("R5 mcast disabled", addr_a, 64, 1'b0, 1'b0);
    mcen = 1;
    mcl[0] = addr_b;
    load_list(1, 6);
    frame("R7 table cleared on reload", addr_a, 64, 1'b0, 1'b0);
    frame("R7 new entry present", addr_b, 64, 1'b1, 1'b1);
    mcl[0] = addr_a; mcl[1] = addr_b;
    load_list(2, 11);
    frame("R7 count floor first", addr_a, 64, 1'b1, 1'b1);
    frame("R7 count floor excess ignored", addr_b, 64, 1'b0, 1'b0);
    mcen = 0;
  endtask

  task automatic t_clamp();
    for (int i = 0; i < 64; i++) mcl[i] = addr_a;
    mcl[64] = addr_b;
    load_list(65, 70 * 6);
    mcen = 1;
    frame("R8 clamp first 64", addr_a, 64, 1'b1, 1'b1);
    frame("R8 clamp 65th ignored", addr_b, 64, 1'b0, 1'b0);
    mcl[64] = addr_c; mcl[63] = addr_b;
    load_list(65, 70 * 6);
    frame("R8 entry 64 applied", addr_b, 64, 1'b1, 1'b1);
    mcen = 0;
  endtask

  task automatic t_promisc();
    promisc = 1;
    frame("R3 promisc unknown unicast", 48'h1234_5678_9A00, 64, 1'b1, 1'b0);
    bdis = 1;
    frame("R3 promisc broadcast", 48'hFFFF_FFFF_FFFF, 64, 1'b1, 1'b0);
    bdis = 0;
    frame("R10 promisc short frame", 48'h1234_5678_9A00, 4, 1'b0, 1'b0);
    promisc = 0;
  endtask

  task automatic t_minlen();
    minlen = 2;
    frame("R10 floor 5 rejects 4", 48'hFFFF_FFFF_FFFF, 4, 1'b0, 1'b0);
    frame("R10 floor 5 accepts 5", 48'hFFFF_FFFF_FFFF, 5, 1'b1, 1'b1);
    minlen = 60;
    frame("R10 below min", 48'hFFFF_FFFF_FFFF, 59, 1'b0, 1'b0);
    frame("R10 at min", 48'hFFFF_FFFF_FFFF, 60, 1'b1, 1'b1);
    minlen = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    addr_a = 48'h0100_005E_0001;
    addr_b = addr_a;
    for (int i = 2; i < 256; i++) begin
      addr_b[47:40] = 8'(i);
      if (hidx(addr_b) != hidx(addr_a)) break;
    end
    addr_c = addr_b;
    for (int i = 1; i < 256; i++) begin
      addr_c[39:32] = 8'(i);
      if (hidx(addr_c) != hidx(addr_a) && hidx(addr_c) != hidx(addr_b)) break;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_unicast();
    t_bcast();
    t_mcast();
    t_clamp();
    t_promisc();
    t_minlen();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule